// File: doc/BRIEF.md
# Multicast Destination Mask Predictor

This block sits beside a requesting cache controller in a snooping multiprocessor. When the controller misses, it presents the block address and the kind of access it needs: a shared read or an exclusive write. One cycle later the block returns a destination vector with one bit per processor. The coherence request is then multicast to the processors whose bits are set, so it does not have to be broadcast to every node.

Predictions come from a direct-mapped table. Each entry holds a tag, the last known owner and the last known set of sharers. A shared read only needs to reach the owner. An exclusive write must reach the owner and every sharer. When no entry matches, the block falls back to a full broadcast. The requester's own bit is always set, so the request is always delivered locally.

When a transaction resolves, the memory side reports the actual owner and sharers for that block address. This feedback overwrites the matching table slot in one cycle, so later predictions for that block use the newer information.

Top module: `mcast_mask_predictor`

## Requirements
- R1: After reset, `pred_valid` is low and every table slot is empty. The first request after reset therefore predicts a miss.
- R2: A request strobed on `req_valid` at one clock edge produces `pred_valid` high for exactly the following cycle. A new request can be accepted on every cycle.
- R3: The slot index is the low log2(TABLE_DEPTH) bits of the block address, and the remaining upper bits form the tag. A request whose index matches a slot but whose tag differs is a miss.
- R4: On a miss, `pred_hit` is 0 and `pred_mask` is all ones (broadcast).
- R5: On a hit for a shared read (`req_excl`=0), `pred_mask` contains only the stored owner bit and the requester's own bit.
- R6: On a hit for an exclusive write (`req_excl`=1), `pred_mask` is the bitwise OR of the stored owner bit, the stored sharer vector and the requester's own bit.
- R7: Whenever `pred_valid` is high, bit SELF_ID of `pred_mask` is set.
- R8: A feedback strobe overwrites the slot selected by `fb_addr` at that clock edge, replacing any earlier entry with a different tag. A request captured at the same edge already sees the new contents.
- R9: While `pred_valid` is low, `pred_mask` is zero and `pred_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request strobe |
| req_addr | input | ADDR_W | Block address of the miss |
| req_excl | input | 1 | 1 = exclusive write, 0 = shared read |
| fb_valid | input | 1 | Feedback strobe |
| fb_addr | input | ADDR_W | Block address the feedback describes |
| fb_owner | input | log2(NPROC) | Actual owner processor number |
| fb_sharers | input | NPROC | Actual sharer vector, bit i = processor i |
| pred_valid | output | 1 | Prediction is present this cycle |
| pred_hit | output | 1 | Table slot matched the request |
| pred_mask | output | NPROC | Predicted destination vector |

## Verification
The following rules are checked by assertions on every cycle:
- the one-cycle timing of `pred_valid`;
- the requester's own bit being set whenever a prediction is shown;
- a broadcast on every miss;
- at most two destinations on a shared-read hit;
- a zero mask while idle;
- a feedback write leaving the chosen slot valid with the new tag.

Other behaviour can only be shown by the bench scenarios, because it depends on earlier traffic:
- the exact owner and sharer content of a mask;
- aliasing between addresses that share an index;
- a feedback write and a request landing on the same edge;
- retraining a slot that has gone stale.

The bench keeps its own model of the table and compares every output on every cycle.

// File: rtl/mcpred_pkg.sv
package mcpred_pkg;

    typedef enum logic {
        ACC_SHARED = 1'b0,
        ACC_EXCL   = 1'b1
    } access_kind_e;

endpackage

// File: rtl/mcpred_table.sv
module mcpred_table #(
    parameter int NPROC       = 16,
    parameter int TABLE_DEPTH = 64,
    parameter int ADDR_W      = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [$clog2(NPROC)-1:0]  wr_owner,
    input  logic [NPROC-1:0]          wr_sharers,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic                      rd_hit,
    output logic [$clog2(NPROC)-1:0]  rd_owner,
    output logic [NPROC-1:0]          rd_sharers
);
    localparam int ID_W  = $clog2(NPROC);
    localparam int IDX_W = $clog2(TABLE_DEPTH);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic [ID_W-1:0]  owner;
        logic [NPROC-1:0] sharers;
    } slot_t;

    slot_t slot_d [TABLE_DEPTH];
    slot_t slot_q [TABLE_DEPTH];

    logic [IDX_W-1:0] wr_idx;
    logic [TAG_W-1:0] wr_tag;
    logic [IDX_W-1:0] rd_idx;
    logic [TAG_W-1:0] rd_tag;

    assign wr_idx = wr_addr[IDX_W-1:0];
    assign wr_tag = wr_addr[ADDR_W-1:IDX_W];
    assign rd_idx = rd_addr[IDX_W-1:0];
    assign rd_tag = rd_addr[ADDR_W-1:IDX_W];

    always_comb begin
        for (int i = 0; i < TABLE_DEPTH; i++) begin
            slot_d[i] = slot_q[i];
        end
        if (wr_en) begin
            slot_d[wr_idx].valid   = 1'b1;
            slot_d[wr_idx].tag     = wr_tag;
            slot_d[wr_idx].owner   = wr_owner;
            slot_d[wr_idx].sharers = wr_sharers;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < TABLE_DEPTH; i++) begin
            if (!rst_n) begin
                slot_q[i] <= '0;
            end else begin
                slot_q[i] <= slot_d[i];
            end
        end
    end

    assign rd_hit     = slot_q[rd_idx].valid && (slot_q[rd_idx].tag == rd_tag);
    assign rd_owner   = slot_q[rd_idx].owner;
    assign rd_sharers = slot_q[rd_idx].sharers;

    assert_fb_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (slot_q[$past(wr_idx)].valid && slot_q[$past(wr_idx)].tag == $past(wr_tag)
                   && slot_q[$past(wr_idx)].owner == $past(wr_owner)))
        else $error("feedback write did not land in slot");

endmodule

// File: rtl/mcpred_mask_gen.sv
module mcpred_mask_gen #(
    parameter int NPROC   = 16,
    parameter int SELF_ID = 0
) (
    input  logic                     active,
    input  logic                     hit,
    input  mcpred_pkg::access_kind_e kind,
    input  logic [$clog2(NPROC)-1:0] owner,
    input  logic [NPROC-1:0]         sharers,
    output logic [NPROC-1:0]         mask
);
    localparam int ID_W = $clog2(NPROC);

    logic want_sharers;
    assign want_sharers = (kind == mcpred_pkg::ACC_EXCL);

    for (genvar g = 0; g < NPROC; g++) begin : g_bit
        if (g == SELF_ID) begin : g_self
            assign mask[g] = active;
        end else begin : g_other
            assign mask[g] = active &
                             (~hit | (owner == ID_W'(g)) | (want_sharers & sharers[g]));
        end
    end

endmodule

// File: rtl/mcast_mask_predictor.sv
module mcast_mask_predictor #(
    parameter int NPROC       = 16,
    parameter int TABLE_DEPTH = 64,
    parameter int ADDR_W      = 32,
    parameter int SELF_ID     = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_excl,
    input  logic                     fb_valid,
    input  logic [ADDR_W-1:0]        fb_addr,
    input  logic [$clog2(NPROC)-1:0] fb_owner,
    input  logic [NPROC-1:0]         fb_sharers,
    output logic                     pred_valid,
    output logic                     pred_hit,
    output logic [NPROC-1:0]         pred_mask
);
    import mcpred_pkg::*;

    localparam int ID_W = $clog2(NPROC);

    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] addr;
        access_kind_e      kind;
    } req_state_t;

    req_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = req_valid;
        if (req_valid) begin
            st_d.addr = req_addr;
            st_d.kind = req_excl ? ACC_EXCL : ACC_SHARED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pend: 1'b0, addr: '0, kind: ACC_SHARED};
        end else begin
            st_q <= st_d;
        end
    end

    logic             tbl_hit;
    logic [ID_W-1:0]  tbl_owner;
    logic [NPROC-1:0] tbl_sharers;

    mcpred_table #(
        .NPROC      (NPROC),
        .TABLE_DEPTH(TABLE_DEPTH),
        .ADDR_W     (ADDR_W)
    ) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (fb_valid),
        .wr_addr   (fb_addr),
        .wr_owner  (fb_owner),
        .wr_sharers(fb_sharers),
        .rd_addr   (st_q.addr),
        .rd_hit    (tbl_hit),
        .rd_owner  (tbl_owner),
        .rd_sharers(tbl_sharers)
    );

    mcpred_mask_gen #(
        .NPROC  (NPROC),
        .SELF_ID(SELF_ID)
    ) mask_i (
        .active (st_q.pend),
        .hit    (tbl_hit),
        .kind   (st_q.kind),
        .owner  (tbl_owner),
        .sharers(tbl_sharers),
        .mask   (pred_mask)
    );

    assign pred_valid = st_q.pend;
    assign pred_hit   = st_q.pend & tbl_hit;

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> pred_valid) else $error("prediction missing after request");

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !pred_valid) else $error("prediction without request");

    assert_self_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> pred_mask[SELF_ID]) else $error("own bit clear");

    assert_miss_bcast_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && !pred_hit) |-> (&pred_mask)) else $error("miss not broadcast");

    assert_shared_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && pred_hit && !$past(req_excl)) |-> ($countones(pred_mask) <= 2))
        else $error("shared hit mask too wide");

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |-> (pred_mask == '0 && !pred_hit)) else $error("idle mask not zero");

endmodule

// File: tb/mcast_mask_predictor_tb.sv
`timescale 1ns/1ps
module mcast_mask_predictor_tb_top;
    localparam int NP    = 16;
    localparam int DEPTH = 64;
    localparam int AW    = 32;
    localparam int SELF  = 0;
    localparam int IW    = $clog2(NP);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic req_excl = 1'b0;
    logic fb_valid = 1'b0;
    logic [AW-1:0] fb_addr = '0;
    logic [IW-1:0] fb_owner = '0;
    logic [NP-1:0] fb_sharers = '0;
    logic pred_valid, pred_hit;
    logic [NP-1:0] pred_mask;

    always #4 clk = ~clk;

    mcast_mask_predictor #(.NPROC(NP), .TABLE_DEPTH(DEPTH), .ADDR_W(AW), .SELF_ID(SELF)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_excl(req_excl), .fb_valid(fb_valid), .fb_addr(fb_addr),
        .fb_owner(fb_owner), .fb_sharers(fb_sharers), .pred_valid(pred_valid),
        .pred_hit(pred_hit), .pred_mask(pred_mask));

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit            m_v [DEPTH];
    logic [AW-1:0] m_a [DEPTH];
    int            m_o [DEPTH];
    logic [NP-1:0] m_s [DEPTH];

    task automatic chk(input bit ok, input string req, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] actual=%0h expected=%0h", req, tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    // one clock: drive at negedge, model updates at posedge, compare at next negedge
    task automatic cyc(input bit rv, input logic [AW-1:0] ra, input bit rx,
                       input bit fv, input logic [AW-1:0] fa, input int fo,
                       input logic [NP-1:0] fs, input string tag);
        bit e_hit;
        logic [NP-1:0] e_mask;
        int ix;
        req_valid = rv; req_addr = ra; req_excl = rx;
        fb_valid = fv; fb_addr = fa; fb_owner = IW'(fo); fb_sharers = fs;
        @(posedge clk);
        if (fv) begin
            ix = int'(fa % DEPTH);
            m_v[ix] = 1; m_a[ix] = fa; m_o[ix] = fo; m_s[ix] = fs;
        end
        ix = int'(ra % DEPTH);
        e_hit = rv && m_v[ix] && (m_a[ix] == ra);
        e_mask = '0;
        if (rv) begin
            if (!e_hit) e_mask = '1;
            else begin
                e_mask[m_o[ix]] = 1'b1;
                if (rx) e_mask = e_mask | m_s[ix];
                e_mask[SELF] = 1'b1;
            end
        end
        @(negedge clk);
        req_valid = 0; fb_valid = 0;
        chk(pred_valid == rv, "R2", tag, 64'(pred_valid), 64'(rv));
        chk(pred_hit == e_hit, rv ? "R3" : "R9", tag, 64'(pred_hit), 64'(e_hit));
        if (!rv)        chk(pred_mask == e_mask, "R9", tag, 64'(pred_mask), 64'(e_mask));
        else if (!e_hit) chk(pred_mask == e_mask, "R4", tag, 64'(pred_mask), 64'(e_mask));
        else if (!rx)   chk(pred_mask == e_mask, "R5", tag, 64'(pred_mask), 64'(e_mask));
        else            chk(pred_mask == e_mask, "R6", tag, 64'(pred_mask), 64'(e_mask));
        if (rv) chk(pred_mask[SELF] == 1'b1, "R7", tag, 64'(pred_mask[SELF]), 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    localparam logic [AW-1:0] A = 32'h0000_1205;
    localparam logic [AW-1:0] B = A + DEPTH;
    localparam logic [AW-1:0] C = 32'h0000_0733;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m_v[i] = 0; m_a[i] = '0; m_o[i] = 0; m_s[i] = '0; end
        repeat (3) @(negedge clk);
        chk(pred_valid == 1'b0, "R1", "reset", 64'(pred_valid), 0);
        chk(pred_mask == '0, "R1", "reset", 64'(pred_mask), 0);
        rst_n = 1'b1;
        // R1: table empty, first request misses
        cyc(1, A, 0, 0, '0, 0, '0, "R1_first_miss");
        cyc(0, '0, 0, 1, A, 5, 16'h0300, "R8_train_A");
        // R2: back-to-back requests, shared then exclusive
        cyc(1, A, 0, 0, '0, 0, '0, "R5_shared_A");
        cyc(1, A, 1, 0, '0, 0, '0, "R6_excl_A");
        // R3: same index, different tag
        cyc(1, B, 1, 0, '0, 0, '0, "R3_alias_miss");
        // R8: feedback and request on the same edge
        cyc(1, B, 0, 1, B, 3, 16'h8000, "R8_same_edge");
        cyc(1, A, 0, 0, '0, 0, '0, "R8_A_evicted");
        cyc(1, B, 1, 0, '0, 0, '0, "R6_excl_B");
        // R7: owner is self, empty sharers
        cyc(0, '0, 0, 1, C, SELF, 16'h0000, "R7_train_C");
        cyc(1, C, 1, 0, '0, 0, '0, "R7_self_owner");
        cyc(0, '0, 0, 0, '0, 0, '0, "R9_idle");
        // mixed traffic over a small set of aliasing addresses
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] ra, fa;
            ra = AW'($urandom_range(0, 7) + DEPTH * $urandom_range(0, 2));
            fa = AW'($urandom_range(0, 7) + DEPTH * $urandom_range(0, 2));
            cyc(bit'($urandom_range(0, 1)), ra, bit'($urandom_range(0, 1)),
                bit'($urandom_range(0, 1)), fa, int'($urandom_range(0, NP - 1)),
                NP'($urandom), "R8_mixed");
        end
        summary();
        $finish;
    end
endmodule